// File: doc/BRIEF.md
# Legacy Keyboard Port SMI Trap

The block watches decoded host I/O cycles aimed at the keyboard data port (60h) and the keyboard command port (64h). Each read or write to one of these ports sets a sticky trap status bit, and an enabled status bit drives a system-management interrupt request. A USB interrupt level can also be routed to the same request.

All of this is controlled through one 16-bit control/status register. The status bits are cleared by writing 1 to them. The block can also let the A20 gate write sequence pass through without being trapped. That sequence is a command write of D1h to port 64h, then a data write to port 60h, then a write of FFh to port 64h. While the sequence is in progress, the SMI request is held off. If an SMI cause came up during the sequence, the block can raise its own end-of-pass request once the sequence completes.

Top module: `kbd_smi_trap`

## Requirements
- R1: An access to port 60h or 64h sets a status bit. Bit 8 is a read of 60h, bit 9 a write of 60h, bit 10 a read of 64h and bit 11 a write of 64h. Accesses to other addresses set nothing.
- R2: A status bit sets even when its enable is 0. In that case `smi_o` stays 0.
- R3: Enable bits 0 to 3 gate status bits 8 to 11 in turn. `smi_o` is 1 while any status bit is set together with its enable, and it stays 1 until that status bit is cleared.
- R4: Writing 1 to a status bit clears it. Writing 0 to a status bit leaves it unchanged. Bits 15:12 always read as 0.
- R5: With bit 4 set, `usb_irq_i` drives `smi_o`. With bit 4 clear, `usb_irq_i` has no effect on `smi_o`.
- R6: Bit 5 enables pass-through. With bit 5 set, the sequence D1h written to 64h, then any write to 60h, then FFh written to 64h sets no status bit. Read-only bit 6 is 1 from the first step of the sequence until the last step.
- R7: While the sequence is in progress, any other access to 60h or 64h aborts it: bit 6 returns to 0 and that access is trapped as usual. With bit 5 clear, no access is suppressed.
- R8: Writing bit 5 as 0 returns bit 6 to 0. While bit 6 is 1, `smi_o` is held at 0.
- R9: If an SMI cause was present while bit 6 was 1, and bit 7 is 1 when the sequence completes, `smi_o` asserts after the sequence and stays asserted until bit 7 is written as 0. If bit 7 is 0 at completion, no such request is made.
- R10: If an event and a write-1 clear hit the same status bit in the same cycle, the bit ends up set.
- R11: Reset sets the register to 0, clears the pass-through state and any pending end-of-pass request, and drives `smi_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| io_valid_i | input | 1 | Decoded I/O cycle present this clock |
| io_write_i | input | 1 | 1 = write cycle, 0 = read cycle |
| io_addr_i | input | 16 | I/O port address |
| io_data_i | input | 8 | Write data byte of the I/O cycle |
| usb_irq_i | input | 1 | USB interrupt level |
| reg_we_i | input | 1 | Control/status register write strobe |
| reg_wdata_i | input | 16 | Control/status register write data |
| reg_rdata_o | output | 16 | Control/status register read value |
| smi_o | output | 1 | SMI request level |

## Verification
The bench steps through every one of the four port events against every single-enable setting. This separates a wrong status bit position from a wrong gating between enable and status. The A20 sequence is run in several forms, each of which shows whether suppression, the in-progress flag and the trap on abort each behave on their own:
- complete;
- broken by a read;
- broken by a mistyped command byte;
- cancelled by writing the enable to 0;
- with pass-through disabled.

A USB interrupt raised during the sequence is run once with the end-of-pass enable set and once with it clear, which separates the hold-off from the deferred request. Finally, an event and a clear are driven onto the same status bit in the same cycle.

// File: rtl/kbd_trap_pkg.sv
package kbd_trap_pkg;
  localparam int unsigned NUM_EV = 4;  // rd60, wr60, rd64, wr64
  localparam int unsigned EV_RD_DATA = 0;
  localparam int unsigned EV_WR_DATA = 1;
  localparam int unsigned EV_RD_CMD  = 2;
  localparam int unsigned EV_WR_CMD  = 3;

  localparam int unsigned BIT_USB_EN = 4;
  localparam int unsigned BIT_PT_EN  = 5;
  localparam int unsigned BIT_PT_ACT = 6;
  localparam int unsigned BIT_END_EN = 7;
  localparam int unsigned BIT_STS_LO = 8;

  typedef enum logic [1:0] {
    PT_IDLE   = 2'd0,
    PT_ARMED  = 2'd1,
    PT_LOADED = 2'd2
  } pt_state_e;
endpackage

// File: rtl/kbd_io_decode.sv
module kbd_io_decode
  import kbd_trap_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] DATA_PORT = 'h60,
  parameter logic [ADDR_W-1:0] CMD_PORT  = 'h64
) (
  input  logic              io_valid_i,
  input  logic              io_write_i,
  input  logic [ADDR_W-1:0] io_addr_i,
  output logic [NUM_EV-1:0] ev_o
);
  // event index: bit1 selects command port, bit0 selects write
  for (genvar i = 0; i < NUM_EV; i++) begin : g_ev
    localparam logic [ADDR_W-1:0] PORT = (i / 2 == 1) ? CMD_PORT : DATA_PORT;
    localparam logic IS_WR = (i % 2 == 1);
    assign ev_o[i] = io_valid_i && (io_write_i == IS_WR) && (io_addr_i == PORT);
  end
endmodule

// File: rtl/kbd_a20_fsm.sv
module kbd_a20_fsm
  import kbd_trap_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter logic [DATA_W-1:0] CMD_OPEN  = 'hD1,
  parameter logic [DATA_W-1:0] CMD_CLOSE = 'hFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pt_en_i,
  input  logic              pt_off_i,
  input  logic [NUM_EV-1:0] ev_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              active_o,
  output logic              suppress_o,
  output logic              complete_o
);
  pt_state_e state_q, state_d;
  logic any_ev, wr_cmd, wr_data;
  logic complete_raw;

  assign any_ev  = |ev_i;
  assign wr_cmd  = ev_i[EV_WR_CMD];
  assign wr_data = ev_i[EV_WR_DATA];

  always_comb begin
    state_d      = state_q;
    suppress_o   = 1'b0;
    complete_raw = 1'b0;
    if (pt_en_i) begin
      unique case (state_q)
        PT_IDLE: begin
          if (wr_cmd && data_i == CMD_OPEN) begin
            state_d    = PT_ARMED;
            suppress_o = 1'b1;
          end
        end
        PT_ARMED: begin
          if (wr_data) begin
            state_d    = PT_LOADED;
            suppress_o = 1'b1;
          end else if (any_ev) begin
            state_d = PT_IDLE;
          end
        end
        PT_LOADED: begin
          if (wr_cmd && data_i == CMD_CLOSE) begin
            state_d      = PT_IDLE;
            suppress_o   = 1'b1;
            complete_raw = 1'b1;
          end else if (any_ev) begin
            state_d = PT_IDLE;
          end
        end
        default: state_d = PT_IDLE;
      endcase
    end
    if (pt_off_i) state_d = PT_IDLE;
  end

  assign complete_o = complete_raw && !pt_off_i;
  assign active_o   = (state_q != PT_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= PT_IDLE;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/kbd_trap_regs.sv
module kbd_trap_regs
  import kbd_trap_pkg::*;
#(
  parameter int unsigned REG_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  input  logic [NUM_EV-1:0] ev_i,
  input  logic              suppress_i,
  input  logic              active_i,
  input  logic              complete_i,
  input  logic              usb_irq_i,
  output logic              pt_en_o,
  output logic              pt_off_o,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              smi_o
);
  localparam int unsigned STS_HI = BIT_STS_LO + NUM_EV - 1;

  logic [NUM_EV-1:0] trap_en_q, status_q, status_clr, trap_ev;
  logic usb_en_q, pt_en_q, end_en_q;
  logic deferred_q, end_pend_q;
  logic cause, end_clr;
  logic unused_wdata;

  assign trap_ev    = ev_i & ~{NUM_EV{suppress_i}};
  assign status_clr = reg_we_i ? reg_wdata_i[STS_HI:BIT_STS_LO] : '0;
  assign pt_off_o   = reg_we_i && !reg_wdata_i[BIT_PT_EN];
  assign end_clr    = reg_we_i && !reg_wdata_i[BIT_END_EN];
  assign pt_en_o    = pt_en_q;

  assign cause = (|(status_q & trap_en_q)) || (usb_en_q && usb_irq_i);
  assign smi_o = !active_i && (cause || end_pend_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trap_en_q  <= '0;
      usb_en_q   <= 1'b0;
      pt_en_q    <= 1'b0;
      end_en_q   <= 1'b0;
      status_q   <= '0;
      deferred_q <= 1'b0;
      end_pend_q <= 1'b0;
    end else begin
      if (reg_we_i) begin
        trap_en_q <= reg_wdata_i[NUM_EV-1:0];
        usb_en_q  <= reg_wdata_i[BIT_USB_EN];
        pt_en_q   <= reg_wdata_i[BIT_PT_EN];
        end_en_q  <= reg_wdata_i[BIT_END_EN];
      end
      // set wins over write-1 clear
      status_q <= (status_q & ~status_clr) | trap_ev;
      // cause seen while sequence is active; dropped when sequence leaves
      if (active_i) deferred_q <= deferred_q | cause;
      if (!active_i || complete_i || pt_off_o) deferred_q <= 1'b0;
      if (active_i && (pt_off_o || |ev_i) && !complete_i && !suppress_i) deferred_q <= 1'b0;
      // end-of-pass request: clear wins over set
      if (end_clr)
        end_pend_q <= 1'b0;
      else if (complete_i && end_en_q && (deferred_q || cause))
        end_pend_q <= 1'b1;
    end
  end

  always_comb begin
    reg_rdata_o                         = '0;
    reg_rdata_o[NUM_EV-1:0]             = trap_en_q;
    reg_rdata_o[BIT_USB_EN]             = usb_en_q;
    reg_rdata_o[BIT_PT_EN]              = pt_en_q;
    reg_rdata_o[BIT_PT_ACT]             = active_i;
    reg_rdata_o[BIT_END_EN]             = end_en_q;
    reg_rdata_o[STS_HI:BIT_STS_LO]      = status_q;
  end

  assign unused_wdata = ^{reg_wdata_i[REG_W-1:STS_HI+1], reg_wdata_i[BIT_PT_ACT]};
endmodule

// File: rtl/kbd_smi_trap.sv
module kbd_smi_trap
  import kbd_trap_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned REG_W  = 16,
  parameter logic [ADDR_W-1:0] DATA_PORT = 'h60,
  parameter logic [ADDR_W-1:0] CMD_PORT  = 'h64,
  parameter logic [DATA_W-1:0] CMD_OPEN  = 'hD1,
  parameter logic [DATA_W-1:0] CMD_CLOSE = 'hFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              io_valid_i,
  input  logic              io_write_i,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic [DATA_W-1:0] io_data_i,
  input  logic              usb_irq_i,
  input  logic              reg_we_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              smi_o
);
  logic [NUM_EV-1:0] ev;
  logic pt_en, pt_off, active, suppress, complete;

  kbd_io_decode #(
    .ADDR_W(ADDR_W), .DATA_PORT(DATA_PORT), .CMD_PORT(CMD_PORT)
  ) u_decode (
    .io_valid_i(io_valid_i),
    .io_write_i(io_write_i),
    .io_addr_i (io_addr_i),
    .ev_o      (ev)
  );

  kbd_a20_fsm #(
    .DATA_W(DATA_W), .CMD_OPEN(CMD_OPEN), .CMD_CLOSE(CMD_CLOSE)
  ) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pt_en_i   (pt_en),
    .pt_off_i  (pt_off),
    .ev_i      (ev),
    .data_i    (io_data_i),
    .active_o  (active),
    .suppress_o(suppress),
    .complete_o(complete)
  );

  kbd_trap_regs #(.REG_W(REG_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .reg_we_i   (reg_we_i),
    .reg_wdata_i(reg_wdata_i),
    .ev_i       (ev),
    .suppress_i (suppress),
    .active_i   (active),
    .complete_i (complete),
    .usb_irq_i  (usb_irq_i),
    .pt_en_o    (pt_en),
    .pt_off_o   (pt_off),
    .reg_rdata_o(reg_rdata_o),
    .smi_o      (smi_o)
  );
endmodule

// File: rtl/kbd_smi_trap_chk.sv
module kbd_smi_trap_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned REG_W  = 16,
  parameter logic [ADDR_W-1:0] DATA_PORT = 'h60,
  parameter logic [ADDR_W-1:0] CMD_PORT  = 'h64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              io_valid_i,
  input logic              io_write_i,
  input logic [ADDR_W-1:0] io_addr_i,
  input logic              reg_we_i,
  input logic [REG_W-1:0]  reg_wdata_i,
  input logic [REG_W-1:0]  reg_rdata_o,
  input logic              smi_o
);
  logic [3:0] keep;
  assign keep = reg_rdata_o[11:8] & ~(reg_we_i ? reg_wdata_i[11:8] : 4'h0);

  p_rd_data_sets_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_valid_i && !io_write_i && io_addr_i == DATA_PORT |=> reg_rdata_o[8]);

  p_rd_cmd_sets_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_valid_i && !io_write_i && io_addr_i == CMD_PORT |=> reg_rdata_o[10]);

  p_status_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (keep != 4'h0) |=> ((reg_rdata_o[11:8] & $past(keep)) == $past(keep)));

  p_hold_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[6] |-> !smi_o);

  p_pt_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && !reg_wdata_i[5] |=> !reg_rdata_o[6]);

  p_no_cause_no_smi_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[4:0] == 5'h0 && !reg_rdata_o[7] |-> !smi_o);

  p_upper_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[15:12] == 4'h0);
endmodule

bind kbd_smi_trap kbd_smi_trap_chk #(
  .ADDR_W(ADDR_W), .REG_W(REG_W), .DATA_PORT(DATA_PORT), .CMD_PORT(CMD_PORT)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .io_valid_i (io_valid_i),
  .io_write_i (io_write_i),
  .io_addr_i  (io_addr_i),
  .reg_we_i   (reg_we_i),
  .reg_wdata_i(reg_wdata_i),
  .reg_rdata_o(reg_rdata_o),
  .smi_o      (smi_o)
);

// File: tb/kbd_smi_trap_bench.sv
`timescale 1ns/1ps
module kbd_smi_trap_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic io_valid = 1'b0, io_write = 1'b0, usb_irq = 1'b0, reg_we = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_data = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] rdata;
  logic smi;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  kbd_smi_trap u_kbd_smi_trap (
    .clk_i(clk), .rst_ni(rst_n), .io_valid_i(io_valid), .io_write_i(io_write),
    .io_addr_i(io_addr), .io_data_i(io_data), .usb_irq_i(usb_irq),
    .reg_we_i(reg_we), .reg_wdata_i(reg_wdata), .reg_rdata_o(rdata), .smi_o(smi)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic io(input logic wr, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_valid = 1'b1; io_write = wr; io_addr = a; io_data = d;
    @(negedge clk);
    io_valid = 1'b0;
  endtask

  task automatic wreg(input logic [15:0] v);
    @(negedge clk);
    reg_we = 1'b1; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  // event index i: bit1 = command port, bit0 = write
  function automatic logic [15:0] ev_addr(input int i);
    return (i >= 2) ? 16'h0064 : 16'h0060;
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset reg", rdata, 16'h0000);
    chk("R11 reset smi", {15'd0, smi}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1/R2: enables off, each event sets its own bit, no smi
    for (int i = 0; i < 4; i++) begin
      io(logic'(i % 2), ev_addr(i), 8'h12);
      chk("R1 status position", rdata, 16'h1 << (8 + i));
      chk("R2 no smi when disabled", {15'd0, smi}, 16'h0);
      wreg(16'h0F00);
      chk("R4 w1c clears", rdata, 16'h0000);
    end
    io(1'b1, 16'h0061, 8'h00);
    io(1'b0, 16'h0160, 8'h00);
    chk("R1 other address ignored", rdata, 16'h0000);

    // R3: every enable against every event
    for (int e = 0; e < 4; e++) begin
      for (int j = 0; j < 4; j++) begin
        wreg(16'h1 << e);
        io(logic'(j % 2), ev_addr(j), 8'h00);
        chk("R3 status+enable", rdata, (16'h1 << e) | (16'h1 << (8 + j)));
        chk("R3 smi gating", {15'd0, smi}, {15'd0, e == j});
        wreg((16'h1 << e) | 16'h0F00);
        chk("R3 smi drops after clear", {15'd0, smi}, 16'h0);
      end
    end

    // R4: writing 0 to status leaves it
    io(1'b0, 16'h0064, 8'h00);
    wreg(16'h0000);
    chk("R4 zero write keeps status", rdata, 16'h0400);
    wreg(16'hFF00);
    chk("R4 upper bits read zero", rdata, 16'h0000);

    // R5: usb gating
    @(negedge clk); usb_irq = 1'b1; #1;
    chk("R5 usb ignored when disabled", {15'd0, smi}, 16'h0);
    wreg(16'h0010);
    chk("R5 usb drives smi", {15'd0, smi}, 16'h1);
    @(negedge clk); usb_irq = 1'b0; #1;
    chk("R5 usb low", {15'd0, smi}, 16'h0);

    // R6: full pass-through
    wreg(16'h002F);
    io(1'b1, 16'h0064, 8'hD1);
    chk("R6 open suppressed, flag set", rdata, 16'h006F);
    io(1'b1, 16'h0060, 8'hDF);
    chk("R6 data suppressed, flag set", rdata, 16'h006F);
    io(1'b1, 16'h0064, 8'hFF);
    chk("R6 close suppressed, flag clear", rdata, 16'h002F);
    chk("R6 no smi", {15'd0, smi}, 16'h0);

    // R7: abort by a read of 60h
    io(1'b1, 16'h0064, 8'hD1);
    io(1'b0, 16'h0060, 8'h00);
    chk("R7 abort traps read", rdata, 16'h012F);
    chk("R7 abort smi", {15'd0, smi}, 16'h1);
    wreg(16'h0F2F);
    // R7: wrong close byte aborts and traps
    io(1'b1, 16'h0064, 8'hD1);
    io(1'b1, 16'h0060, 8'h01);
    io(1'b1, 16'h0064, 8'hFE);
    chk("R7 bad close traps", rdata, 16'h082F);
    wreg(16'h0F0F);
    // R7: pass-through disabled
    io(1'b1, 16'h0064, 8'hD1);
    chk("R7 disabled no suppress", rdata, 16'h080F);
    wreg(16'h0F00);

    // R8: writing enable 0 cancels sequence
    wreg(16'h0020);
    io(1'b1, 16'h0064, 8'hD1);
    chk("R8 flag set", rdata, 16'h0060);
    wreg(16'h0000);
    chk("R8 flag forced off", rdata, 16'h0000);

    // R9: deferred request with end enable
    wreg(16'h00B0);
    io(1'b1, 16'h0064, 8'hD1);
    @(negedge clk); usb_irq = 1'b1; #1;
    chk("R8 smi held during sequence", {15'd0, smi}, 16'h0);
    @(negedge clk); usb_irq = 1'b0;
    io(1'b1, 16'h0060, 8'hDF);
    io(1'b1, 16'h0064, 8'hFF);
    chk("R9 end-of-pass smi", {15'd0, smi}, 16'h1);
    io(1'b0, 16'h0070, 8'h00);
    chk("R9 request held", {15'd0, smi}, 16'h1);
    wreg(16'h0030);
    chk("R9 cleared by end enable 0", {15'd0, smi}, 16'h0);
    // R9: no request when end enable is 0
    io(1'b1, 16'h0064, 8'hD1);
    @(negedge clk); usb_irq = 1'b1;
    @(negedge clk); usb_irq = 1'b0;
    io(1'b1, 16'h0060, 8'hDF);
    io(1'b1, 16'h0064, 8'hFF);
    chk("R9 no request without enable", {15'd0, smi}, 16'h0);
    wreg(16'h0000);

    // R10: set beats clear
    io(1'b1, 16'h0060, 8'h00);
    @(negedge clk);
    io_valid = 1'b1; io_write = 1'b1; io_addr = 16'h0060;
    reg_we = 1'b1; reg_wdata = 16'h0200;
    @(negedge clk);
    io_valid = 1'b0; reg_we = 1'b0;
    chk("R10 set wins", rdata, 16'h0200);

    // R11: reset mid-run
    wreg(16'h00BF);
    @(negedge clk); rst_n = 1'b0; #1;
    chk("R11 async reset", rdata, 16'h0000);
    @(negedge clk); rst_n = 1'b1;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule